// File: doc/BRIEF.md
# Bit-Oriented Message Receiver with Majority Validation

This block watches the serial data-link bit stream of a T1 extended-superframe line and recovers short bit-oriented messages from it. While idle, it searches for the opening flag, which is eight ones in a row. When no flag turns up within a window of 32 received bits, it reports an incorrect-sync event and starts a fresh window.

Once locked, the block cuts the stream into 16-bit codewords and checks the format of each one. Every well-formed codeword goes into a sliding history that holds the ten most recent codewords. A message is declared valid, and its 6-bit code is latched, when at least seven of those ten codewords carry the same code. The valid state ends as soon as fewer than seven of the last ten match the latched code. At that point a one-cycle message-invalid pulse is raised, if the pulse is enabled.

The input stream uses a qualifier strobe, and the block takes every bit that is offered. It has no ready signal and never applies back-pressure, so the upstream framer may present a bit in any cycle. Cycles without the strobe are ignored. The enable input and the results at the outputs are plain level and pulse signals.

Top module: `bomrx_top`

## Requirements
- R1: After reset, msg_valid, sync_err and biv_pulse are 0 and msg_code is 0.
- R2: While hunting, the receiver locks on eight consecutive 1 bits. If 32 strobed bits pass without a lock, sync_err pulses for exactly one cycle and a new 32-bit window begins, so a further error follows 32 bits later.
- R3: A codeword is 16 bits, taken in this order: eight 1 bits, a 0, the six payload bits with payload bit 0 first, and a final 0.
- R4: msg_valid rises, with msg_code set to the payload, in the cycle after the clock edge that takes the last bit of a codeword that makes at least 7 of the last 10 codewords carry that payload.
- R5: Six equal codewords out of ten do not make a message valid.
- R6: When fewer than 7 of the last 10 codewords match the latched code, msg_valid falls and biv_pulse is high for one cycle in the same cycle, provided biv_en is 1.
- R7: With biv_en at 0, leaving the valid state produces no biv_pulse.
- R8: While en is 0, no events are produced and the state is cleared: msg_valid falls without a biv_pulse, sync_err stays 0, the codeword history is emptied, and hunting restarts with a fresh window.
- R9: Cycles with bit_vld at 0 leave the receiver unchanged.
- R10: A locked frame that breaks the R3 format drops the lock and is not counted as a codeword.
- R11: msg_code holds its value while msg_valid stays high, and it keeps the last latched code after msg_valid falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receiver enable; at 0 the receiver is cleared and silent |
| biv_en | input | 1 | Enables the message-invalid pulse |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies bit_in in this cycle; always accepted |
| msg_code | output | 6 | Latched message payload |
| msg_valid | output | 1 | Message valid level |
| sync_err | output | 1 | One-cycle pulse: no flag within the 32-bit window |
| biv_pulse | output | 1 | One-cycle pulse: valid state left |

## Verification
Every result appears one cycle after the clock edge that samples its cause. A rising or falling msg_valid and a biv_pulse follow the edge that takes the last bit of the deciding codeword. sync_err follows the edge that takes the 32nd bit of the window, and a drop of en clears msg_valid after one edge. The driver stamps each expected event with its due cycle when it presents the causing bit. The monitor samples on falling edges and compares the kind, the due cycle and the code of each observed event against the front of the queue, so any early, late or unexpected event is reported.

// File: rtl/bomrx_pkg.sv
package bomrx_pkg;
  localparam int CODE_W    = 6;   // payload bits per codeword
  localparam int FLAG_ONES = 8;   // ones in the opening flag
  localparam int SYNC_WIN  = 32;  // bits allowed to find a flag
  localparam int HIST_N    = 10;  // codewords in the vote window
  localparam int VOTE_NEED = 7;   // matches needed for valid
endpackage

// File: rtl/bomrx_sync.sv
// Flag hunt, window watchdog and codeword framing.
module bomrx_sync #(
  parameter int FLAG_ONES = 8,
  parameter int CODE_W    = 6,
  parameter int SYNC_WIN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic              cw_stb,
  output logic [CODE_W-1:0] cw_code,
  output logic              sync_err
);
  localparam int FRAME_W = FLAG_ONES + CODE_W + 2;
  localparam int WIN_W   = $clog2(SYNC_WIN);
  localparam int PH_W    = $clog2(FRAME_W);
  localparam int RUN_W   = $clog2(FLAG_ONES);

  logic [FRAME_W-1:0] sr_q, sr_nxt;
  logic [WIN_W-1:0]   win_q;
  logic [RUN_W-1:0]   run_q;
  logic [PH_W-1:0]    ph_q;
  logic               locked_q;
  logic               frame_ok, last_bit;

  // newest bit enters at the top; oldest bit sits at index 0
  assign sr_nxt   = {bit_in, sr_q[FRAME_W-1:1]};
  assign frame_ok = (&sr_nxt[FLAG_ONES-1:0]) && !sr_nxt[FLAG_ONES]
                    && !sr_nxt[FRAME_W-1];
  assign cw_code  = sr_nxt[FRAME_W-2 -: CODE_W];
  assign last_bit = (ph_q == PH_W'(FRAME_W-1));
  assign cw_stb   = en && bit_vld && locked_q && last_bit && frame_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= '0;
      win_q    <= '0;
      run_q    <= '0;
      ph_q     <= '0;
      locked_q <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      sync_err <= 1'b0;
      if (!en) begin
        sr_q     <= '0;
        win_q    <= '0;
        run_q    <= '0;
        ph_q     <= '0;
        locked_q <= 1'b0;
      end else if (bit_vld) begin
        sr_q <= sr_nxt;
        if (!locked_q) begin
          if (bit_in && run_q == RUN_W'(FLAG_ONES-1)) begin
            locked_q <= 1'b1;
            ph_q     <= PH_W'(FLAG_ONES);
            run_q    <= '0;
            win_q    <= '0;
          end else begin
            run_q <= bit_in ? run_q + RUN_W'(1) : '0;
            if (win_q == WIN_W'(SYNC_WIN-1)) begin
              sync_err <= 1'b1;
              win_q    <= '0;
              run_q    <= '0;
            end else begin
              win_q <= win_q + WIN_W'(1);
            end
          end
        end else if (last_bit) begin
          ph_q <= '0;
          if (!frame_ok) locked_q <= 1'b0;
        end else begin
          ph_q <= ph_q + PH_W'(1);
        end
      end
    end
  end

  // R2: the watchdog event is a single-cycle pulse
  a_r2_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);
  // R2: the watchdog only fires while hunting
  a_r2_err_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !locked_q);
  // R10: a broken frame ends the lock
  a_r10_bad_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_vld && locked_q && last_bit && !frame_ok) |=> !locked_q);
endmodule

// File: rtl/bomrx_vote.sv
// Sliding history of codewords and the majority decision.
module bomrx_vote #(
  parameter int CODE_W    = 6,
  parameter int HIST_N    = 10,
  parameter int VOTE_NEED = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              biv_en,
  input  logic              cw_stb,
  input  logic [CODE_W-1:0] cw_code,
  output logic              msg_valid,
  output logic [CODE_W-1:0] msg_code,
  output logic              biv_pulse
);
  localparam int OLD_N = HIST_N - 1;  // entries kept besides the newest
  localparam int CNT_W = $clog2(HIST_N + 1);

  logic [CODE_W-1:0] h_code [OLD_N];
  logic [OLD_N-1:0]  h_vld;
  logic [CNT_W-1:0]  n_new, n_lat;

  always_comb begin
    n_new = CNT_W'(1);
    n_lat = (cw_code == msg_code) ? CNT_W'(1) : CNT_W'(0);
    for (int i = 0; i < OLD_N; i++) begin
      if (h_vld[i] && h_code[i] == cw_code)  n_new = n_new + CNT_W'(1);
      if (h_vld[i] && h_code[i] == msg_code) n_lat = n_lat + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < OLD_N; i++) h_code[i] <= '0;
      h_vld     <= '0;
      msg_valid <= 1'b0;
      msg_code  <= '0;
      biv_pulse <= 1'b0;
    end else begin
      biv_pulse <= 1'b0;
      if (!en) begin
        h_vld     <= '0;
        msg_valid <= 1'b0;
      end else if (cw_stb) begin
        h_code[0] <= cw_code;
        h_vld[0]  <= 1'b1;
        for (int i = 1; i < OLD_N; i++) begin
          h_code[i] <= h_code[i-1];
          h_vld[i]  <= h_vld[i-1];
        end
        if (!msg_valid && n_new >= CNT_W'(VOTE_NEED)) begin
          msg_valid <= 1'b1;
          msg_code  <= cw_code;
        end else if (msg_valid && n_lat < CNT_W'(VOTE_NEED)) begin
          msg_valid <= 1'b0;
          biv_pulse <= biv_en;
        end
      end
    end
  end

  // R4: the valid state only begins on a codeword
  a_r4_rise_on_cw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(cw_stb));
  // R6: an invalid pulse marks the cycle valid was left
  a_r6_biv_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    biv_pulse |-> (!msg_valid && $past(msg_valid)));
  // R7: no invalid pulse while it is disabled
  a_r7_biv_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !biv_en |=> !biv_pulse);
  // R11: the latched code holds while valid
  a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(msg_valid)) |-> $stable(msg_code));
endmodule

// File: rtl/bomrx_top.sv
module bomrx_top import bomrx_pkg::*; #(
  parameter int P_CODE_W    = CODE_W,
  parameter int P_FLAG_ONES = FLAG_ONES,
  parameter int P_SYNC_WIN  = SYNC_WIN,
  parameter int P_HIST_N    = HIST_N,
  parameter int P_VOTE_NEED = VOTE_NEED
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                biv_en,
  input  logic                bit_in,
  input  logic                bit_vld,
  output logic [P_CODE_W-1:0] msg_code,
  output logic                msg_valid,
  output logic                sync_err,
  output logic                biv_pulse
);
  logic                cw_stb;
  logic [P_CODE_W-1:0] cw_code;

  bomrx_sync #(
    .FLAG_ONES(P_FLAG_ONES), .CODE_W(P_CODE_W), .SYNC_WIN(P_SYNC_WIN)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_in(bit_in), .bit_vld(bit_vld),
    .cw_stb(cw_stb), .cw_code(cw_code), .sync_err(sync_err)
  );

  bomrx_vote #(
    .CODE_W(P_CODE_W), .HIST_N(P_HIST_N), .VOTE_NEED(P_VOTE_NEED)
  ) u_vote (
    .clk(clk), .rst_n(rst_n), .en(en), .biv_en(biv_en),
    .cw_stb(cw_stb), .cw_code(cw_code),
    .msg_valid(msg_valid), .msg_code(msg_code), .biv_pulse(biv_pulse)
  );

  // R8: a disabled receiver raises nothing
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!msg_valid && !sync_err && !biv_pulse));
  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!msg_valid && !sync_err && !biv_pulse && msg_code == '0));
endmodule

// File: tb/sim_bomrx_top.sv
`timescale 1ns/1ps
module sim_bomrx_top;
  localparam int EV_RISE = 1, EV_FALL = 2, EV_BIV = 3, EV_ERR = 4;

  logic clk = 0, rst_n = 0, en = 0, biv_en = 0, bit_in = 0, bit_vld = 0;
  logic [5:0] msg_code;
  logic msg_valid, sync_err, biv_pulse;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit run_mon = 0, done = 0, prev_v = 0;
  int q_kind[$], q_due[$];
  logic [5:0] q_code[$];
  string q_tag[$];

  bomrx_top u0 (.clk(clk), .rst_n(rst_n), .en(en), .biv_en(biv_en),
    .bit_in(bit_in), .bit_vld(bit_vld), .msg_code(msg_code),
    .msg_valid(msg_valid), .sync_err(sync_err), .biv_pulse(biv_pulse));

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input int due, input logic [5:0] c, input string tag);
    q_kind.push_back(k); q_due.push_back(due); q_code.push_back(c); q_tag.push_back(tag);
  endtask

  task automatic take(input int k, input logic [5:0] c);
    int ek, ed; logic [5:0] ec; string et;
    if (q_kind.size() == 0) begin
      chk(0, "unexpected event", k, 0);
    end else begin
      ek = q_kind.pop_front(); ed = q_due.pop_front();
      ec = q_code.pop_front(); et = q_tag.pop_front();
      chk(k == ek, {et, " kind"}, k, ek);
      chk(cyc == ed, {et, " cycle"}, cyc, ed);
      if (ek == EV_RISE) chk(c == ec, {et, " code"}, c, ec);
    end
  endtask

  // monitor: events in fixed order rise/fall, biv, err
  always @(negedge clk) begin
    if (run_mon) begin
      if (msg_valid && !prev_v) take(EV_RISE, msg_code);
      if (!msg_valid && prev_v) take(EV_FALL, 6'd0);
      if (biv_pulse) take(EV_BIV, 6'd0);
      if (sync_err) take(EV_ERR, 6'd0);
    end
    prev_v = msg_valid;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send_bit(input logic b, input int k1, input int k2,
                          input logic [5:0] c, input string tag);
    @(negedge clk);
    bit_in = b; bit_vld = 1;
    if (k1 != 0) push(k1, cyc + 1, c, tag);
    if (k2 != 0) push(k2, cyc + 1, c, tag);
    @(negedge clk);
    bit_vld = 0;
  endtask

  // R3 order: eight ones, 0, payload bit0..bit5, 0 (bad: final bit 1)
  task automatic send_cw(input logic [5:0] c, input bit bad, input int k1,
                         input int k2, input string tag);
    logic b;
    for (int i = 0; i < 16; i++) begin
      if (i < 8) b = 1'b1;
      else if (i == 8) b = 1'b0;
      else if (i < 15) b = c[i-9];
      else b = bad;
      if (i == 15) send_bit(b, k1, k2, c, tag);
      else send_bit(b, 0, 0, c, tag);
    end
  endtask

  task automatic send_zeros(input int n, input bit err_last, input string tag);
    for (int i = 0; i < n; i++)
      send_bit(1'b0, (err_last && i == n-1) ? EV_ERR : 0, 0, 6'd0, tag);
  endtask

  localparam logic [5:0] A = 6'h15, B = 6'h2A, C = 6'h01;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(msg_valid == 0 && sync_err == 0 && biv_pulse == 0, "R1 flags", msg_valid, 0);
    chk(msg_code == 0, "R1 code", msg_code, 0);
    run_mon = 1;
    en = 1; biv_en = 1;

    // R2, R9: two windows of zeros, gaps between bits, error every 32 bits
    send_zeros(32, 1, "R2 first window");
    repeat (5) @(negedge clk);
    send_zeros(32, 1, "R2 restarted window");

    // R3, R4, R5: seven codewords of A
    for (int i = 0; i < 6; i++) send_cw(A, 0, 0, 0, "R5");
    chk(msg_valid == 0, "R5 six of ten", msg_valid, 0);
    send_cw(A, 0, EV_RISE, 0, "R4 rise A");

    // R6: four B's leave A with six of ten
    for (int i = 0; i < 3; i++) send_cw(B, 0, 0, 0, "R6");
    send_cw(B, 0, EV_FALL, EV_BIV, "R6 fall with biv");
    chk(msg_code == A, "R11 code kept after fall", msg_code, A);
    for (int i = 0; i < 2; i++) send_cw(B, 0, 0, 0, "R4");
    send_cw(B, 0, EV_RISE, 0, "R4 rise B");

    // R7: four C's drop B with pulse disabled
    @(negedge clk); biv_en = 0;
    for (int i = 0; i < 3; i++) send_cw(C, 0, 0, 0, "R7");
    send_cw(C, 0, EV_FALL, 0, "R7 fall no biv");
    chk(msg_code == B, "R11 code kept B", msg_code, B);

    // R10: corrupt C frame must not count
    send_cw(C, 1, 0, 0, "R10");
    send_cw(C, 0, 0, 0, "R10");
    send_cw(C, 0, 0, 0, "R10");
    chk(msg_valid == 0, "R10 bad frame not counted", msg_valid, 0);
    send_cw(C, 0, EV_RISE, 0, "R10 rise C");

    // R8: disabling clears valid without biv
    @(negedge clk); biv_en = 1; en = 0;
    push(EV_FALL, cyc + 1, 6'd0, "R8 fall on disable");
    send_zeros(40, 0, "R8");
    chk(msg_valid == 0 && sync_err == 0, "R8 quiet while off", msg_valid, 0);
    @(negedge clk); en = 1;
    send_zeros(32, 1, "R8 fresh window");
    for (int i = 0; i < 6; i++) send_cw(A, 0, 0, 0, "R8 history cleared");
    chk(msg_valid == 0, "R8 history cleared", msg_valid, 0);
    send_cw(A, 0, EV_RISE, 0, "R8 rise after clear");

    repeat (10) @(negedge clk);
    chk(q_kind.size() == 0, "missing events", q_kind.size(), 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule